// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block models one function block of a programmable logic array. A fan-in bus of eight signals, widened by eight optional fold-back NAND signals, feeds a shared array of 48 AND terms. Sixteen macrocells draw on that one array. No term belongs to a single macrocell. Each macrocell takes its data from one of three places: one term wired straight to it, an OR over any set of the 48 terms, or its own pin input with no term used. Eight of the terms can be named as local control terms. These drive asynchronous preset and clear, output enables and local clocks. One of them can also be driven out as a universal control term for neighbouring blocks.

The macrocell registers run from one system clock. The clock source of a macrocell is picked by configuration: a global clock, a local control term, a product term of its own, or a universal clock. That source is sampled every system clock. A flip-flop captures on a sampled 0-to-1 change, and a latch is transparent while the source is 1. Preset, clear, universal reset and output enable act on the outputs in the same cycle.

Configuration is one 32-bit word per address. It is accepted only while `rst` is high. Configuration storage is not cleared by reset, so every used word must be written before `rst` is released.

Top module: `pfb_top`

## Requirements
- R1: Config words are written when `cfg_we` and `rst` are both high on a clock edge. Address map: 0..47 term masks; 48+i the OR membership of macrocell i for terms 0..31 (bit t = term t); 64+i its membership for terms 32..47 (bit t-32); 80+i its mode word; 96 and 97 the control-term slots; 98 the misc word. Writes while `rst` is low, and writes to addresses 99 and above, change nothing.
- R2: Array input j is `fanin[j]` for j<8 and NAND j-8 for j>=8. In a term mask, bit 2j set requires input j=1 and bit 2j+1 set requires input j=0. A term is the AND of its required literals, and an all-zero mask gives 0.
- R3: In the mode word, bit 17 (OR select) = 0 makes the data the term indexed by bits 16:11. Bit 17 = 1 makes it the OR of the member terms.
- R4: Mode bit 19 = 1 makes the data `pin_in[i]`, ahead of the R3 choice.
- R5: Mode bit 0 = 0 selects a flip-flop. It loads its data on the edge where the clock source is 1 and was 0 at the previous edge, and holds otherwise. The output shows the new value after that edge. Source by bits 2:1: 0 = `gclk[bit 3]`; 1 = local control term (bits 4:3); 2 = the term indexed by bits 10:5; 3 = `uct_in[2 + bit 3]`.
- R6: Mode bit 0 = 1 selects a latch. It loads its data on every edge while the source is 1 and holds while it is 0.
- R7: Control slot s (6 bits at 6*(s%5) of word 96+s/5) names the term used as local control term s. Mode bit 24 enables preset from slot bits 23:21, and bit 28 enables clear from slot bits 27:25. Either one forces the output at once. Clear wins over preset.
- R8: `uct_in[0]`=1 clears all macrocells at once. `uct_in[1]`=0 drops every output enable. `uct_out` is the slot named by misc bits 10:8 when misc bit 11 is set, and 0 otherwise.
- R9: Mode bits 31:29 = 0 enable the output always. A value k from 1 to 7 makes the enable local control term k.
- R10: Misc bit k enables NAND k. NAND k is the inverse of term k evaluated on its fan-in literals only. A disabled NAND gives 0.
- R11: `por` high at an edge loads each register with mode bit 18. It ranks below clear and preset and above the clock.
- R12: While `rst` is high, every register is cleared on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, also the configuration window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word |
| fanin | input | 8 | Array fan-in signals |
| pin_in | input | 16 | Per-macrocell direct register inputs |
| gclk | input | 2 | Global clock sources |
| uct_in | input | 4 | Universal terms: reset, output enable, two clocks |
| por | input | 1 | Power-on load request |
| mc_out | output | 16 | Macrocell outputs |
| mc_oe | output | 16 | Macrocell output enables |
| uct_out | output | 1 | Local control term driven to the universal net |

## Verification
The main function is run through a vector table of fan-in patterns applied to seven macrocells, all configured as transparent latches. Between them they cover a direct term, a single complemented literal, ORs spread over low and high member words, a fold-back NAND term and an empty term. Each pattern is chosen so that a wrong literal polarity, a dropped OR member, a wrong membership word or a dead NAND changes a different output bit. Directed steps then separate flip-flop from latch behaviour, run all four clock-source kinds, compare preset against clear, check power-on load priority and check the universal reset and enable. They also show that out-of-window configuration writes leave the table results unchanged.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
    localparam int N_IN   = 8;
    localparam int N_NAND = 8;
    localparam int N_PT   = 48;
    localparam int N_MC   = 16;
    localparam int N_LCT  = 8;
    localparam int N_GCLK = 2;
    localparam int N_UCT  = 4;
    localparam int CFG_AW = 7;
    localparam int CFG_DW = 32;

    localparam int ARR_W  = N_IN + N_NAND;
    localparam int MASK_W = 2 * ARR_W;
    localparam int PT_IW  = $clog2(N_PT);
    localparam int LCT_IW = $clog2(N_LCT);
    localparam int MC_IW  = $clog2(N_MC);
    localparam int HI_W   = N_PT - CFG_DW;
    localparam int SLOTS_PER_WORD = CFG_DW / PT_IW;

    localparam int U_RST  = 0;
    localparam int U_OE   = 1;
    localparam int U_CLK0 = 2;

    localparam logic [CFG_AW-1:0] A_ORLO = CFG_AW'(N_PT);
    localparam logic [CFG_AW-1:0] A_ORHI = CFG_AW'(N_PT + N_MC);
    localparam logic [CFG_AW-1:0] A_MODE = CFG_AW'(N_PT + 2 * N_MC);
    localparam logic [CFG_AW-1:0] A_LCT  = CFG_AW'(N_PT + 3 * N_MC);
    localparam logic [CFG_AW-1:0] A_MISC = CFG_AW'(N_PT + 3 * N_MC + 2);

    typedef enum logic [1:0] {
        CK_GLOBAL = 2'd0,
        CK_LOCAL  = 2'd1,
        CK_TERM   = 2'd2,
        CK_UNIV   = 2'd3
    } clk_kind_e;

    typedef struct packed {
        logic [2:0]       oe_sel;
        logic             clr_en;
        logic [2:0]       clr_sel;
        logic             set_en;
        logic [2:0]       set_sel;
        logic             spare;
        logic             use_pin;
        logic             por_val;
        logic             use_or;
        logic [PT_IW-1:0] dir_pt;
        logic [PT_IW-1:0] clk_pt;
        logic [1:0]       clk_idx;
        clk_kind_e        clk_kind;
        logic             is_latch;
    } mode_t;

    function automatic logic pt_eval(input logic [MASK_W-1:0] mask,
                                     input logic [ARR_W-1:0]  x);
        logic ok;
        ok = |mask;
        for (int j = 0; j < ARR_W; j++) begin
            if (mask[2*j] && !x[j])   ok = 1'b0;
            if (mask[2*j+1] && x[j])  ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic pick_pt(input logic [N_PT-1:0]  v,
                                     input logic [PT_IW-1:0] idx);
        return (32'(idx) < N_PT) ? v[idx] : 1'b0;
    endfunction
endpackage

// File: rtl/pfb_cfg.sv
`timescale 1ns/1ps
module pfb_cfg
    import pfb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [CFG_AW-1:0]                  addr,
    input  logic [CFG_DW-1:0]                  wdata,
    output logic [N_PT-1:0][MASK_W-1:0]        pt_mask,
    output logic [N_MC-1:0][N_PT-1:0]          or_mask,
    output mode_t [N_MC-1:0]                   mode,
    output logic [N_LCT-1:0][PT_IW-1:0]        lct_idx,
    output logic [N_NAND-1:0]                  nand_en,
    output logic [LCT_IW-1:0]                  drv_sel,
    output logic                               drv_en
);
    logic [N_MC-1:0][CFG_DW-1:0] or_lo;
    logic [N_MC-1:0][CFG_DW-1:0] or_hi;
    logic [1:0][CFG_DW-1:0]      lct_w;
    logic [CFG_DW-1:0]           misc_w;

    logic hit_pt, hit_lo, hit_hi, hit_mode, hit_lct, hit_misc;
    logic [PT_IW-1:0]  i_pt;
    logic [MC_IW-1:0]  i_lo, i_hi, i_mode;
    logic              i_lct;

    always_comb begin
        hit_pt   = addr <  A_ORLO;
        hit_lo   = (addr >= A_ORLO) && (addr < A_ORHI);
        hit_hi   = (addr >= A_ORHI) && (addr < A_MODE);
        hit_mode = (addr >= A_MODE) && (addr < A_LCT);
        hit_lct  = (addr == A_LCT) || (addr == A_LCT + 1'b1);
        hit_misc = addr == A_MISC;
        i_pt     = PT_IW'(addr);
        i_lo     = MC_IW'(addr - A_ORLO);
        i_hi     = MC_IW'(addr - A_ORHI);
        i_mode   = MC_IW'(addr - A_MODE);
        i_lct    = addr[0] ^ A_LCT[0];
    end

    always_ff @(posedge clk) begin
        if (rst && we) begin
            if (hit_pt)   pt_mask[i_pt] <= wdata[MASK_W-1:0];
            if (hit_lo)   or_lo[i_lo]   <= wdata;
            if (hit_hi)   or_hi[i_hi]   <= wdata;
            if (hit_mode) mode[i_mode]  <= mode_t'(wdata);
            if (hit_lct)  lct_w[i_lct]  <= wdata;
            if (hit_misc) misc_w        <= wdata;
        end
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_or
        assign or_mask[m] = {or_hi[m][HI_W-1:0], or_lo[m]};
    end

    for (genvar s = 0; s < N_LCT; s++) begin : g_slot
        assign lct_idx[s] = lct_w[s / SLOTS_PER_WORD][PT_IW*(s % SLOTS_PER_WORD) +: PT_IW];
    end

    assign nand_en = misc_w[N_NAND-1:0];
    assign drv_sel = misc_w[N_NAND +: LCT_IW];
    assign drv_en  = misc_w[N_NAND + LCT_IW];
endmodule

// File: rtl/pfb_array.sv
`timescale 1ns/1ps
module pfb_array
    import pfb_pkg::*;
(
    input  logic [N_IN-1:0]                fanin,
    input  logic [N_PT-1:0][MASK_W-1:0]    pt_mask,
    input  logic [N_LCT-1:0][PT_IW-1:0]    lct_idx,
    input  logic [N_NAND-1:0]              nand_en,
    output logic [N_PT-1:0]                pt,
    output logic [N_LCT-1:0]               lct
);
    logic [N_NAND-1:0] nand_o;
    logic [ARR_W-1:0]  x;

    // Fold-back terms see fan-in literals only, which keeps the array acyclic.
    for (genvar k = 0; k < N_NAND; k++) begin : g_nand
        assign nand_o[k] = nand_en[k] &
            ~pt_eval({{(MASK_W-2*N_IN){1'b0}}, pt_mask[k][2*N_IN-1:0]},
                     {{N_NAND{1'b0}}, fanin});
    end

    assign x = {nand_o, fanin};

    for (genvar t = 0; t < N_PT; t++) begin : g_pt
        assign pt[t] = pt_eval(pt_mask[t], x);
    end

    for (genvar s = 0; s < N_LCT; s++) begin : g_lct
        assign lct[s] = pick_pt(pt, lct_idx[s]);
    end
endmodule

// File: rtl/pfb_cell.sv
`timescale 1ns/1ps
module pfb_cell
    import pfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_t             m,
    input  logic [N_PT-1:0]   pt,
    input  logic [N_PT-1:0]   or_row,
    input  logic [N_LCT-1:0]  lct,
    input  logic              pin,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_UCT-1:0]  uct_in,
    input  logic              por,
    output logic              out,
    output logic              oe,
    output logic              q,
    output logic              clr,
    output logic              set
);
    logic d, csel, prev, fire;

    always_comb begin
        unique case (m.clk_kind)
            CK_GLOBAL: csel = gclk[m.clk_idx[0]];
            CK_LOCAL:  csel = lct[m.clk_idx];
            CK_TERM:   csel = pick_pt(pt, m.clk_pt);
            default:   csel = m.clk_idx[0] ? uct_in[U_CLK0+1] : uct_in[U_CLK0];
        endcase
        if (m.use_pin)     d = pin;
        else if (m.use_or) d = |(pt & or_row);
        else               d = pick_pt(pt, m.dir_pt);
        clr  = uct_in[U_RST] | (m.clr_en & lct[m.clr_sel]);
        set  = m.set_en & lct[m.set_sel];
        oe   = uct_in[U_OE] & ((m.oe_sel == 3'd0) | lct[m.oe_sel]);
        fire = m.is_latch ? csel : (csel & ~prev);
    end

    always_ff @(posedge clk) begin
        prev <= csel;
        if (rst)        q <= 1'b0;
        else if (clr)   q <= 1'b0;
        else if (set)   q <= 1'b1;
        else if (por)   q <= m.por_val;
        else if (fire)  q <= d;
    end

    assign out = clr ? 1'b0 : (set ? 1'b1 : q);
endmodule

// File: rtl/pfb_top.sv
`timescale 1ns/1ps
module pfb_top
    import pfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   fanin,
    input  logic [N_MC-1:0]   pin_in,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_UCT-1:0]  uct_in,
    input  logic              por,
    output logic [N_MC-1:0]   mc_out,
    output logic [N_MC-1:0]   mc_oe,
    output logic              uct_out
);
    logic [N_PT-1:0][MASK_W-1:0] pt_mask;
    logic [N_MC-1:0][N_PT-1:0]   or_mask;
    mode_t [N_MC-1:0]            mode;
    logic [N_LCT-1:0][PT_IW-1:0] lct_idx;
    logic [N_NAND-1:0]           nand_en;
    logic [LCT_IW-1:0]           drv_sel;
    logic                        drv_en;
    logic [N_PT-1:0]             pt;
    logic [N_LCT-1:0]            lct;
    logic [N_MC-1:0]             q_vec, clr_vec, set_vec;

    pfb_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .pt_mask(pt_mask), .or_mask(or_mask), .mode(mode), .lct_idx(lct_idx),
        .nand_en(nand_en), .drv_sel(drv_sel), .drv_en(drv_en)
    );

    pfb_array u_arr (
        .fanin(fanin), .pt_mask(pt_mask), .lct_idx(lct_idx),
        .nand_en(nand_en), .pt(pt), .lct(lct)
    );

    for (genvar i = 0; i < N_MC; i++) begin : g_mc
        pfb_cell u_cell (
            .clk(clk), .rst(rst), .m(mode[i]), .pt(pt), .or_row(or_mask[i]),
            .lct(lct), .pin(pin_in[i]), .gclk(gclk), .uct_in(uct_in), .por(por),
            .out(mc_out[i]), .oe(mc_oe[i]), .q(q_vec[i]),
            .clr(clr_vec[i]), .set(set_vec[i])
        );
    end

    assign uct_out = drv_en & lct[drv_sel];
endmodule

// File: rtl/pfb_chk.sv
`timescale 1ns/1ps
module pfb_chk
    import pfb_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [N_UCT-1:0]            uct_in,
    input logic [N_MC-1:0]             mc_out,
    input logic [N_MC-1:0]             mc_oe,
    input logic [N_MC-1:0]             q_vec,
    input logic [N_MC-1:0]             clr_vec,
    input logic [N_MC-1:0]             set_vec,
    input logic [N_PT-1:0][MASK_W-1:0] cfg_pt,
    input mode_t [N_MC-1:0]            cfg_mode
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    p_ureset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        uct_in[U_RST] |-> (mc_out == '0));

    p_uoe_off_r8: assert property (@(posedge clk) disable iff (rst)
        !uct_in[U_OE] |-> (mc_oe == '0));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((clr_vec & mc_out) == '0));

    p_preset_drives_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((set_vec & ~clr_vec & ~mc_out) == '0));

    p_reset_zero_r12: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(rst) |-> (q_vec == '0));

    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(rst) |-> ($stable(cfg_pt) && $stable(cfg_mode)));
endmodule

bind pfb_top pfb_chk u_chk (
    .clk(clk), .rst(rst), .uct_in(uct_in), .mc_out(mc_out), .mc_oe(mc_oe),
    .q_vec(q_vec), .clr_vec(clr_vec), .set_vec(set_vec),
    .cfg_pt(pt_mask), .cfg_mode(mode)
);

// File: tb/sim_pfb_top.sv
`timescale 1ns/1ps
module sim_pfb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  fanin = '0;
    logic [15:0] pin_in = '0;
    logic [1:0]  gclk = 2'b01;
    logic [3:0]  uct_in = 4'b0010;
    logic        por = 1'b0;
    logic [15:0] mc_out, mc_oe;
    logic        uct_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pfb_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fanin(fanin), .pin_in(pin_in), .gclk(gclk),
        .uct_in(uct_in), .por(por), .mc_out(mc_out), .mc_oe(mc_oe),
        .uct_out(uct_out)
    );

    // upper byte: fan-in, lower byte: expected mc_out[6:0]
    localparam logic [15:0] TBL [7] = '{
        16'h001A, 16'h0305, 16'h041E, 16'h0C1A, 16'h8118, 16'h2150, 16'hFF4D
    };

    function automatic logic [31:0] mw(input logic latch, input logic [1:0] kind,
        input logic [1:0] cidx, input logic [5:0] cpt, input logic [5:0] dpt,
        input logic uor, input logic porv, input logic pin,
        input logic [2:0] ssel, input logic sen, input logic [2:0] csel,
        input logic cen, input logic [2:0] oe);
        return {oe, cen, csel, sen, ssel, 1'b0, pin, porv, uor, dpt, cpt, cidx, kind, latch};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 99; a++) wr(a, 32'h0);
        for (int i = 0; i < 16; i++) wr(80 + i, mw(1,0,0,0,5,0,0,0,0,0,0,0,0));
        wr(0, 32'h5); wr(1, 32'h2); wr(2, 32'h90); wr(3, 32'h4000);
        wr(4, 32'h10000); wr(6, 32'h100); wr(7, 32'h1000); wr(9, 32'h40);
        wr(40, 32'h400);
        wr(48 + 2, 32'h5); wr(48 + 3, 32'hA); wr(64 + 6, 32'h100);
        wr(80 + 0, mw(1,0,0,0,0,0,0,0,0,0,0,0,0));
        wr(80 + 1, mw(1,0,0,0,1,0,0,0,0,0,0,0,0));
        wr(80 + 2, mw(1,0,0,0,0,1,0,0,0,0,0,0,0));
        wr(80 + 3, mw(1,0,0,0,0,1,0,0,0,0,0,0,0));
        wr(80 + 4, mw(1,0,0,0,4,0,0,0,0,0,0,0,0));
        wr(80 + 6, mw(1,0,0,0,0,1,0,0,0,0,0,0,0));
        wr(80 + 7, mw(0,0,1,0,5,0,0,1,0,0,0,0,0));
        wr(80 + 8, mw(1,0,1,0,5,0,0,1,0,0,0,0,0));
        wr(80 + 9, mw(1,0,0,0,5,0,0,0,1,1,2,1,0));
        wr(80 + 10, mw(0,0,1,0,5,0,1,1,0,0,0,0,0));
        wr(80 + 11, mw(1,0,0,0,5,0,0,0,0,0,0,0,3));
        wr(80 + 12, mw(0,1,0,0,5,0,0,1,0,0,0,0,0));
        wr(80 + 13, mw(0,3,0,0,5,0,0,1,0,0,0,0,0));
        wr(80 + 14, mw(0,2,0,3,5,0,0,1,0,0,0,0,0));
        wr(96, 32'h00187189);
        wr(98, 32'h901);
        wr(112, 32'hFFFFFFFF);
        step; step;
        chk("R12 reset outputs", 32'(mc_out), 32'h0);
        chk("R9 reset enables", 32'(mc_oe), 32'hF7FF);
        rst = 1'b0;
        wr(80, mw(1,0,0,0,1,0,0,0,0,0,0,0,0));

        // R2 R3 R10 R1: table of fan-in patterns through latched macrocells
        for (int v = 0; v < 7; v++) begin
            fanin = TBL[v][15:8];
            step;
            chk($sformatf("R2/R3/R10/R1 vector %0d", v), 32'(mc_out[6:0]), 32'(TBL[v][6:0]));
        end
        fanin = 8'h00;
        step;

        // R4 R5: flip-flop on gclk1 via pin path
        pin_in[7] = 1'b1;
        step;
        chk("R5 no edge hold", 32'(mc_out[7]), 32'h0);
        gclk[1] = 1'b1;
        step;
        chk("R4/R5 capture on edge", 32'(mc_out[7]), 32'h1);
        pin_in[7] = 1'b0; pin_in[8] = 1'b1;
        step;
        chk("R5 source high no edge", 32'(mc_out[7]), 32'h1);
        chk("R6 latch transparent", 32'(mc_out[8]), 32'h1);
        gclk[1] = 1'b0; pin_in[8] = 1'b0;
        step;
        chk("R6 latch holds", 32'(mc_out[8]), 32'h1);

        // R7 R9 R8: control terms
        fanin = 8'h10; #1;
        chk("R7 preset immediate", 32'(mc_out[9]), 32'h1);
        chk("R9 oe from local term", 32'(mc_oe[11]), 32'h1);
        chk("R8 uct_out driven", 32'(uct_out), 32'h1);
        fanin = 8'h50; #1;
        chk("R7 clear wins", 32'(mc_out[9]), 32'h0);
        @(negedge clk);
        fanin = 8'h00; #1;
        chk("R8 uct_out low", 32'(uct_out), 32'h0);
        step;

        // R11: power-on load
        por = 1'b1;
        step;
        por = 1'b0;
        chk("R11 por loads one", 32'(mc_out[10]), 32'h1);
        chk("R11 por loads zero", 32'(mc_out[7]), 32'h0);

        // R8: universal reset and enable
        uct_in = 4'b0011; #1;
        chk("R8 universal reset", 32'(mc_out), 32'h0);
        uct_in = 4'b0000; #1;
        chk("R8 universal oe off", 32'(mc_oe), 32'h0);
        uct_in = 4'b0010;
        step;

        // R5: local, term and universal clock sources
        pin_in[14:12] = 3'b111;
        step;
        chk("R5 no source edge", 32'(mc_out[14:12]), 32'h0);
        fanin = 8'h88; uct_in = 4'b0110;
        step;
        chk("R5 local clock", 32'(mc_out[12]), 32'h1);
        chk("R5 universal clock", 32'(mc_out[13]), 32'h1);
        chk("R5 term clock", 32'(mc_out[14]), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule